// File: doc/BRIEF.md
# Set-Associative Data Cache Lookup with Page-Offset Index and Physical Tags

This block is the read lookup path of a 64 KB data cache. The cache has 16 ways of 4 KB each, 64 sets per way and 64-byte lines. The set index and the byte offset together take the low 12 bits of the virtual address. Those bits lie inside the untranslated page offset, so the tag and data arrays can be read while a separate translator converts the virtual page number. Capacity therefore comes from the number of ways and not from more sets.

A lookup is accepted on a rising edge. The arrays are read with the virtual index on that edge. In the next cycle, the translator supplies the 12-bit physical page number on `xl_ppn`. Every way's stored physical tag is compared against it, and the single matching way drives the hit, the way number and a 64-bit word of the line. Because the tags are physical, two virtual aliases of one physical word find the same line. A virtual tag, which could report a miss while the right data is present, is never compared. A separate fill port writes a whole line into a way of a set. The way is picked by a per-set round-robin pointer, or is the way that already holds that tag.

Handshake rules:
- Lookups use valid/ready. The source holds `lk_valid` and `lk_vaddr` until `lk_ready` is high on a rising edge.
- The response is valid/ready. While `rsp_valid` is high and `rsp_ready` is low, the response is held and no new lookup is taken. `xl_ppn` must stay stable over that time.
- The fill port is always ready. A fill in a cycle blocks lookup acceptance in that same cycle.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset no line is valid, `rsp_valid` is 0 and `lk_ready` is 1. Any lookup before the first fill misses.
- R2: The set is chosen only by virtual address bits [11:6] and the word by bits [5:3]. Lookups that differ only in bits [31:12] and carry the same physical page number return the same hit, way and data.
- R3: `rsp_hit` is 1 exactly when some way of the indexed set holds a valid tag equal to `xl_ppn`. `rsp_way` then gives that way's number (0 to 15).
- R4: On a hit, `rsp_data` is 64-bit word k of the line, where k = vaddr[5:3] and word k occupies line bits [64k+63:64k]. On a miss, `rsp_data` is 0.
- R5: A lookup accepted on rising edge N gives `rsp_valid` = 1 in the cycle after N. `xl_ppn` is compared during that cycle. Back-to-back lookups are accepted on consecutive edges while `rsp_ready` is 1.
- R6: While `rsp_valid` = 1 and `rsp_ready` = 0, the response stays valid and unchanged, and `lk_ready` is 0. The response reflects the array contents at the edge where the lookup was accepted, even if a fill lands during the stall.
- R7: `fill_ready` is always 1. When `fill_valid` = 1, `lk_ready` is 0. A fill of physical line address `fill_paddr` (tag = bits [23:12], set = bits [11:6]) is seen by every lookup accepted on a later edge.
- R8: Each set has its own round-robin pointer, reset to way 0. A fill whose tag is not present in the set writes the pointed-to way and advances the pointer by one, wrapping from 15 to 0.
- R9: A fill whose tag is already valid in the set overwrites that same way and leaves the pointer unchanged. At most one way of a set ever hits.
- R10: A lookup whose `xl_ppn` matches no valid tag of the set misses, even when the same line is present under a different page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| xl_ppn | input | 12 | Translated physical page number, presented in the response cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | Number of the hitting way |
| rsp_data | output | 64 | Selected 64-bit word, zero on a miss |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill accepted (always high) |
| fill_paddr | input | 24 | Physical address of the line being filled |
| fill_line | input | 512 | Line contents, word k in bits [64k+63:64k] |

## Verification
A lookup taken on a rising edge has its hit, way and data due in the following cycle. A held response stays due every cycle until it is consumed. A fill changes only what lookups accepted on later edges can see. The bench model takes each rising edge in order: it consumes the response, applies the fill, then snapshots the indexed set of any accepted lookup. Two nanoseconds after each falling edge, once the new inputs and `xl_ppn` have settled, it compares valid, ready, hit, way and data against that snapshot and the current page number.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Default geometry of the cache lookup path
  localparam int unsigned DEF_VA_W       = 32;
  localparam int unsigned DEF_PA_W       = 24;
  localparam int unsigned DEF_PAGE_BITS  = 12;
  localparam int unsigned DEF_WAYS       = 16;
  localparam int unsigned DEF_SETS       = 64;
  localparam int unsigned DEF_LINE_BYTES = 64;
  localparam int unsigned DEF_WORD_BYTES = 8;

  // Width of a counter or index that spans n values (at least one bit)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vipt_way.sv
module vipt_way #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic              peek_valid,
  output logic [TAG_W-1:0]  peek_tag,
  output logic              q_valid,
  output logic [TAG_W-1:0]  q_tag,
  output logic [LINE_W-1:0] q_line
);
  logic [SETS-1:0]   vld;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  // valid bits: cleared by reset, set by a fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  // combinational view used by the fill path to find an existing copy
  assign peek_valid = vld[peek_idx];
  assign peek_tag   = tag_mem[peek_idx];

  // registered read with the virtual index; held while rd_en is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
    end else if (rd_en) begin
      q_valid <= vld[rd_idx];
      q_tag   <= tag_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) q_line <= line_mem[rd_idx];
  end

  // a read and a write never share an edge (fill blocks lookup)
  assert_no_rw_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // a written set reads back as valid on the next edge
  logic              chk_wr;
  logic [IDX_W-1:0]  chk_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_wr  <= 1'b0;
      chk_idx <= '0;
    end else begin
      chk_wr  <= wr_en;
      chk_idx <= wr_idx;
    end
  end
  assert_fill_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr |-> vld[chk_idx]);
endmodule

// File: rtl/vipt_victim.sv
module vipt_victim #(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAY_W = 4,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             keep,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr [SETS];
  logic [WAY_W-1:0] nxt;

  assign victim = ptr[fill_idx];
  assign nxt    = (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SETS); s++) ptr[s] <= '0;
    end else if (fill_en && !keep) begin
      ptr[fill_idx] <= nxt;
    end
  end

  // checker: pointer of the filled set advances only on a new tag
  logic             chk_arm;
  logic [IDX_W-1:0] chk_idx;
  logic [WAY_W-1:0] chk_exp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_arm <= 1'b0;
      chk_idx <= '0;
      chk_exp <= '0;
    end else begin
      chk_arm <= fill_en;
      chk_idx <= fill_idx;
      chk_exp <= keep ? victim : ((victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1);
    end
  end
  assert_rr_pointer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm |-> (ptr[chk_idx] == chk_exp));
endmodule

// File: rtl/vipt_hit_select.sv
module vipt_hit_select #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned WAY_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chk_en,
  input  logic [WAYS-1:0]              vld,
  input  logic [WAYS-1:0][TAG_W-1:0]   tags,
  input  logic [WAYS-1:0][LINE_W-1:0]  lines,
  input  logic [TAG_W-1:0]             ppn,
  output logic                         hit,
  output logic [WAY_W-1:0]             way,
  output logic [LINE_W-1:0]            line
);
  logic [WAYS-1:0] match;

  // physical tag compare per way
  for (genvar g = 0; g < int'(WAYS); g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == ppn);
  end

  // one-hot AND-OR mux and way encoder
  always_comb begin
    line = '0;
    way  = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      line = line | ({LINE_W{match[w]}} & lines[w]);
      if (match[w]) way = way | WAY_W'(w);
    end
  end

  assign hit = |match;

  assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(match));
endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W       = DEF_VA_W,
  parameter int unsigned PA_W       = DEF_PA_W,
  parameter int unsigned PAGE_BITS  = DEF_PAGE_BITS,
  parameter int unsigned WAYS       = DEF_WAYS,
  parameter int unsigned SETS       = DEF_SETS,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
  localparam int unsigned TAG_W  = PA_W - PAGE_BITS,
  localparam int unsigned WAY_W  = idx_bits(WAYS),
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned WORD_W = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [TAG_W-1:0]  xl_ppn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WORD_W-1:0] rsp_data,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [PA_W-1:0]   fill_paddr,
  input  logic [LINE_W-1:0] fill_line
);
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W   = idx_bits(SETS);
  localparam int unsigned WORDS   = LINE_BYTES / WORD_BYTES;
  localparam int unsigned WSEL_W  = idx_bits(WORDS);
  localparam int unsigned WBYTE_W = $clog2(WORD_BYTES);

  initial begin
    assert_index_in_page_R2: assert (OFF_W + IDX_W <= PAGE_BITS)
      else $error("set index reaches into translated bits");
  end

  // ---------------- lookup acceptance ----------------
  logic              s1_valid;
  logic [WSEL_W-1:0] s1_wsel;
  logic              acc;
  logic [IDX_W-1:0]  lk_idx;

  assign fill_ready = 1'b1;
  assign lk_ready   = !fill_valid && (!s1_valid || rsp_ready);
  assign acc        = lk_valid && lk_ready;
  assign lk_idx     = lk_vaddr[OFF_W +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wsel  <= '0;
    end else if (acc) begin
      s1_valid <= 1'b1;
      s1_wsel  <= lk_vaddr[WBYTE_W +: WSEL_W];
    end else if (rsp_ready) begin
      s1_valid <= 1'b0;
    end
  end

  // ---------------- fill decode ----------------
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  assign f_idx = fill_paddr[OFF_W +: IDX_W];
  assign f_tag = fill_paddr[PAGE_BITS +: TAG_W];

  logic [WAYS-1:0]             pk_vld;
  logic [WAYS-1:0][TAG_W-1:0]  pk_tag;
  logic [WAYS-1:0]             pk_hit;
  logic [WAYS-1:0]             way_wr;
  logic [WAYS-1:0]             q_vld;
  logic [WAYS-1:0][TAG_W-1:0]  q_tag;
  logic [WAYS-1:0][LINE_W-1:0] q_line;
  logic [WAY_W-1:0]            victim;
  logic [WAY_W-1:0]            match_way;
  logic [WAY_W-1:0]            wr_way;
  logic                        match_any;

  // ---------------- way arrays ----------------
  for (genvar g = 0; g < int'(WAYS); g++) begin : g_way
    vipt_way #(
      .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (acc),
      .rd_idx     (lk_idx),
      .wr_en      (way_wr[g]),
      .wr_idx     (f_idx),
      .wr_tag     (f_tag),
      .wr_line    (fill_line),
      .peek_idx   (f_idx),
      .peek_valid (pk_vld[g]),
      .peek_tag   (pk_tag[g]),
      .q_valid    (q_vld[g]),
      .q_tag      (q_tag[g]),
      .q_line     (q_line[g])
    );
    assign pk_hit[g] = pk_vld[g] && (pk_tag[g] == f_tag);
    assign way_wr[g] = fill_valid && (wr_way == WAY_W'(g));
  end

  always_comb begin
    match_way = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (pk_hit[w]) match_way = match_way | WAY_W'(w);
    end
  end

  assign match_any = |pk_hit;
  assign wr_way    = match_any ? match_way : victim;

  vipt_victim #(
    .WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .IDX_W(IDX_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_valid),
    .fill_idx (f_idx),
    .keep     (match_any),
    .victim   (victim)
  );

  // ---------------- physical compare and select ----------------
  logic                              sel_hit;
  logic [WAY_W-1:0]                  sel_way;
  logic [LINE_W-1:0]                 sel_line;
  logic [WORDS-1:0][WORD_W-1:0]      sel_words;

  vipt_hit_select #(
    .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W), .WAY_W(WAY_W)
  ) u_hit (
    .clk    (clk),
    .rst_n  (rst_n),
    .chk_en (s1_valid),
    .vld    (q_vld),
    .tags   (q_tag),
    .lines  (q_line),
    .ppn    (xl_ppn),
    .hit    (sel_hit),
    .way    (sel_way),
    .line   (sel_line)
  );

  assign sel_words = sel_line;
  assign rsp_valid = s1_valid;
  assign rsp_hit   = sel_hit;
  assign rsp_way   = sel_way;
  assign rsp_data  = sel_words[s1_wsel];

  // translated bits and in-word byte offset do not reach the arrays
  logic unused_addr_bits;
  assign unused_addr_bits = ^{lk_vaddr, fill_paddr};

  // ---------------- assertions ----------------
  assert_rsp_next_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid &&
      ((xl_ppn != $past(xl_ppn)) ||
       (rsp_hit == $past(rsp_hit) && rsp_way == $past(rsp_way) &&
        rsp_data == $past(rsp_data)))));

  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  assert_fill_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_ready);

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

  assert_fill_unique_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $onehot0(pk_hit));
endmodule

// File: tb/sim_vipt_cache_lookup.sv
module sim_vipt_cache_lookup;
  localparam int WAYS = 16, SETS = 64, LINE_W = 512, TAG_W = 12, WAY_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              lk_valid, lk_ready;
  logic [31:0]       lk_vaddr;
  logic [TAG_W-1:0]  xl_ppn;
  logic              rsp_valid, rsp_ready, rsp_hit;
  logic [WAY_W-1:0]  rsp_way;
  logic [63:0]       rsp_data;
  logic              fill_valid, fill_ready;
  logic [23:0]       fill_paddr;
  logic [LINE_W-1:0] fill_line;

  vipt_cache_lookup u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vaddr(lk_vaddr), .xl_ppn(xl_ppn), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_paddr(fill_paddr), .fill_line(fill_line)
  );

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string scen = "R1 reset state";

  // ---------------- behavioural reference ----------------
  logic [TAG_W-1:0]  mtag [SETS][WAYS];
  bit                mval [SETS][WAYS];
  logic [LINE_W-1:0] mdat [SETS][WAYS];
  int                mptr [SETS];
  bit                pend;
  bit                sv [WAYS];
  logic [TAG_W-1:0]  st [WAYS];
  logic [LINE_W-1:0] sd [WAYS];
  int                sw;

  always @(posedge clk) begin
    bit acc;
    int s, fw;
    if (!rst_n) begin
      pend = 1'b0;
      for (int i = 0; i < SETS; i++) begin
        mptr[i] = 0;
        for (int j = 0; j < WAYS; j++) mval[i][j] = 1'b0;
      end
    end else begin
      acc = lk_valid && !fill_valid && (!pend || rsp_ready);
      if (pend && rsp_ready) pend = 1'b0;
      if (fill_valid) begin
        s  = int'(fill_paddr[11:6]);
        fw = -1;
        for (int j = 0; j < WAYS; j++)
          if (mval[s][j] && mtag[s][j] == fill_paddr[23:12]) fw = j;
        if (fw < 0) begin
          fw = mptr[s];
          mptr[s] = (mptr[s] + 1) % WAYS;
        end
        mval[s][fw] = 1'b1;
        mtag[s][fw] = fill_paddr[23:12];
        mdat[s][fw] = fill_line;
      end
      if (acc) begin
        s = int'(lk_vaddr[11:6]);
        for (int j = 0; j < WAYS; j++) begin
          sv[j] = mval[s][j];
          st[j] = mtag[s][j];
          sd[j] = mdat[s][j];
        end
        sw   = int'(lk_vaddr[5:3]);
        pend = 1'b1;
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", what, scen, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit          eh;
    int          ew;
    logic [63:0] ed;
    chk("R5 rsp_valid", 64'(rsp_valid), 64'(pend));
    chk("R7 lk_ready", 64'(lk_ready), 64'(!fill_valid && (!pend || rsp_ready)));
    chk("R7 fill_ready", 64'(fill_ready), 64'd1);
    if (pend) begin
      eh = 1'b0; ew = 0; ed = '0;
      for (int j = 0; j < WAYS; j++)
        if (sv[j] && st[j] == xl_ppn) begin
          eh = 1'b1; ew = j; ed = sd[j][sw*64 +: 64];
        end
      chk("R3 rsp_hit", 64'(rsp_hit), 64'(eh));
      if (eh) chk("R8 rsp_way", 64'(rsp_way), 64'(ew));
      chk("R4 rsp_data", rsp_data, ed);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && !done) check_cycle();
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [LINE_W-1:0] mkline(int seed);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < 8; k++)
      l[k*64 +: 64] = {32'(seed), 32'(k)} ^ 64'h5A5A_0000_C3C3_0000;
    return l;
  endfunction

  function automatic logic [31:0] va(logic [19:0] up, int set, int word);
    return {up, 6'(set), 3'(word), 3'b000};
  endfunction

  task automatic step(bit lv, logic [31:0] a, logic [TAG_W-1:0] pp, bit rr,
                      bit fv, logic [23:0] fa, logic [LINE_W-1:0] fl);
    lk_valid = lv; lk_vaddr = a; xl_ppn = pp; rsp_ready = rr;
    fill_valid = fv; fill_paddr = fa; fill_line = fl;
    @(negedge clk);
  endtask

  task automatic fill(logic [TAG_W-1:0] pp, int set, int seed);
    step(1'b0, '0, '0, 1'b1, 1'b1, {pp, 6'(set), 6'd0}, mkline(seed));
  endtask

  task automatic lookup(logic [19:0] up, int set, int word, logic [TAG_W-1:0] pp);
    step(1'b1, va(up, set, word), '0, 1'b1, 1'b0, '0, '0);
    step(1'b0, '0, pp, 1'b1, 1'b0, '0, '0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired [%s]", scen);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_vaddr = '0; xl_ppn = '0; rsp_ready = 0;
    fill_valid = 0; fill_paddr = '0; fill_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, '0, '0, 1'b1, 1'b0, '0, '0);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 lk_ready after reset", 64'(lk_ready), 64'd1);

    scen = "R1 lookup before any fill";
    lookup(20'h00ABC, 5, 3, 12'h123);

    scen = "R3 R4 first fill and hit";
    fill(12'h123, 5, 1);
    lookup(20'h00ABC, 5, 3, 12'h123);
    lookup(20'h00ABC, 5, 7, 12'h123);

    scen = "R2 virtual alias";
    lookup(20'h77777, 5, 3, 12'h123);

    scen = "R10 wrong page number";
    lookup(20'h00ABC, 5, 3, 12'h124);

    scen = "R8 round robin set 5";
    for (int i = 0; i < 16; i++) fill(12'h200 + 12'(i), 5, 100 + i);
    lookup(20'h00001, 5, 0, 12'h123);
    lookup(20'h00002, 5, 1, 12'h20F);
    lookup(20'h00003, 5, 2, 12'h201);

    scen = "R9 refill existing tag";
    fill(12'h205, 5, 500);
    lookup(20'h00004, 5, 4, 12'h205);
    fill(12'h210, 5, 510);
    lookup(20'h00005, 5, 5, 12'h210);
    lookup(20'h00006, 5, 6, 12'h200);

    scen = "R8 independent set 9";
    fill(12'h0AA, 9, 900);
    lookup(20'h00007, 9, 1, 12'h0AA);

    scen = "R6 stall with fill";
    step(1'b1, va(20'h11111, 5, 2), '0, 1'b1, 1'b0, '0, '0);
    step(1'b1, va(20'h22222, 5, 3), 12'h201, 1'b0, 1'b0, '0, '0);
    step(1'b1, va(20'h22222, 5, 3), 12'h201, 1'b0, 1'b1, {12'h300, 6'd5, 6'd0}, mkline(700));
    step(1'b1, va(20'h22222, 5, 3), 12'h201, 1'b0, 1'b0, '0, '0);
    step(1'b1, va(20'h22222, 5, 3), 12'h201, 1'b1, 1'b0, '0, '0);
    step(1'b0, '0, 12'h201, 1'b1, 1'b0, '0, '0);
    lookup(20'h00008, 5, 0, 12'h300);

    scen = "R7 fill priority";
    step(1'b1, va(20'h33333, 9, 6), '0, 1'b1, 1'b1, {12'h0BB, 6'd9, 6'd0}, mkline(910));
    step(1'b1, va(20'h33333, 9, 6), '0, 1'b1, 1'b0, '0, '0);
    step(1'b0, '0, 12'h0BB, 1'b1, 1'b0, '0, '0);

    scen = "R5 back-to-back lookups";
    for (int i = 0; i < 8; i++)
      step(1'b1, va(20'(i * 4099), 5, i), (i == 0) ? 12'h2FF : 12'h202 + 12'(i), 1'b1, 1'b0, '0, '0);
    step(1'b0, '0, 12'h20A, 1'b1, 1'b0, '0, '0);
    repeat (3) step(1'b0, '0, '0, 1'b1, 1'b0, '0, '0);

    finish_run();
  end
endmodule